// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block merges the interrupt sources of an audio controller into one summary status word and drives a single level-sensitive interrupt line toward the host. The sources are the response-ring flags, the codec state-change bits qualified by a wake-enable mask, and one buffer-completion flag from each DMA stream. The status word is never latched. It is rebuilt combinationally from its live sources, so clearing a source clears its status bit at once, and any change to the control or state-change registers takes effect on the next evaluation without extra logic.

The block holds three host-visible registers: the interrupt control register, the wake-enable mask and the write-one-to-clear state-change register. A small select-addressed write port and a combinational read port give access to them and to the live status word. When reset is applied, the state-change register is loaded from a present-codec bitmap, which marks every attached codec by its 4-bit address. The interrupt line is registered and follows the sources one clock later.

Top module: `audio_irq_aggr`

## Requirements
- R1: While and right after a synchronous active-high reset, the control register reads 0, the wake mask reads 0, the state-change register reads the present-codec bitmap (bit i set when the codec at address i is attached), and the interrupt line is low.
- R2: A write with select 0 stores the written word ANDed with the writable mask: bits 31 and 30 plus one bit per stream (0xC00000FF for eight streams). Control is unchanged in cycles without such a write.
- R3: A write with select 1 stores the low 14 bits of the written word as the wake mask; it reads back zero-extended (mask 0x3FFF).
- R4: A write with select 2 clears each state-change bit written with 1 and keeps each bit written with 0; outside reset, no state-change bit is ever set.
- R5: Status bits 7:0 (one per stream) equal the stream buffer-completion flags; bits 29 down to the stream count read 0.
- R6: Status bit 30 is 1 when the response-ring interrupt flag is 1, or the response overrun flag is 1, or any state-change bit is 1 at a position where the wake mask is also 1.
- R7: Status bit 31 is 1 exactly when bits 30:0 of the status word ANDed with the control register are nonzero.
- R8: The interrupt line equals (status bit 31 AND control bit 31) as they stood at the previous rising clock edge.
- R9: A write with select 3 (the status word, read-only) changes no register; reads use select 0 for control, 1 for the wake mask, 2 for state-change and 3 for the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| codec_present | input | 14 | Bitmap of attached codecs, loaded into state-change on reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 wake mask, 2 state-change, 3 status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| resp_irq_flag | input | 1 | Response-ring interrupt flag |
| resp_ovr_flag | input | 1 | Response-ring overrun flag |
| stream_done | input | 8 | Buffer-completion flag of each DMA stream |
| irq | output | 1 | Level-sensitive interrupt line |

## Verification
A wrong control or wake value shows at the ports on the very next read of that register and, through the live status word, on the same cycle a source is applied. A state-change bit that fails to clear or is wrongly set keeps bit 30 high while its wake bit is enabled, and this is visible immediately on the status read. A fault in the output stage shows one clock after the status and control values that should drive it, because the line is sampled at the edge after each source change and is also checked before that edge.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int WORD_W     = 32;
    localparam int GLOBAL_BIT = 31;
    localparam int CTRL_BIT   = 30;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_WAKE = 2'd1,
        SEL_SCHG = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic irq_flag;
        logic ovr_flag;
    } ring_flags_t;

    // Writable bits of the control register: both global bits plus one per stream.
    function automatic logic [WORD_W-1:0] ctl_mask(input int n_streams);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < n_streams; i++) begin
            m[i] = 1'b1;
        end
        m[GLOBAL_BIT] = 1'b1;
        m[CTRL_BIT]   = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] zext_codec(input logic [15:0] v, input int n_codec);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < n_codec; i++) begin
            r[i] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/aud_irq_regs.sv
module aud_irq_regs
    import aud_irq_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CODEC   = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CODEC-1:0]   codec_present,
    input  logic                 we,
    input  reg_sel_e             sel,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    ctl_q,
    output logic [N_CODEC-1:0]   wake_q,
    output logic [N_CODEC-1:0]   schg_q
);

    localparam logic [WORD_W-1:0] CTL_MASK = ctl_mask(N_STREAMS);

    logic wr_ctl, wr_wake, wr_schg;

    always_comb begin
        wr_ctl  = we && (sel == SEL_CTL);
        wr_wake = we && (sel == SEL_WAKE);
        wr_schg = we && (sel == SEL_SCHG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= wdata & CTL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= '0;
        end else if (wr_wake) begin
            wake_q <= wdata[N_CODEC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            schg_q <= codec_present;
        end else if (wr_schg) begin
            schg_q <= schg_q & ~wdata[N_CODEC-1:0];
        end
    end

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ctl |=> $stable(ctl_q));

    // R4
    schg_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((schg_q & ~$past(schg_q)) == '0));

    // R3
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_wake |=> $stable(wake_q));

endmodule

// File: rtl/aud_irq_status.sv
module aud_irq_status
    import aud_irq_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CODEC   = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ring_flags_t          ring,
    input  logic [N_CODEC-1:0]   schg,
    input  logic [N_CODEC-1:0]   wake,
    input  logic [N_STREAMS-1:0] done,
    input  logic [WORD_W-1:0]    ctl,
    output logic [WORD_W-1:0]    word
);

    logic [WORD_W-1:0] src_bits;
    logic              ctrl_any;

    always_comb begin
        ctrl_any = ring.irq_flag || ring.ovr_flag || ((schg & wake) != '0);
    end

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            if (i < N_STREAMS) begin : g_stream
                assign src_bits[i] = done[i];
            end else if (i == CTRL_BIT) begin : g_ctrl
                assign src_bits[i] = ctrl_any;
            end else begin : g_zero
                assign src_bits[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        word             = src_bits;
        word[GLOBAL_BIT] = ((src_bits & ctl) != '0);
    end

    // R6
    ring_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ring.irq_flag || ring.ovr_flag) |-> word[CTRL_BIT]);

    // R7
    global_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        word[GLOBAL_BIT] |-> (ctl[WORD_W-2:0] != '0));

endmodule

// File: rtl/aud_irq_out.sv
module aud_irq_out (
    input  logic clk,
    input  logic rst,
    input  logic global_sts,
    input  logic global_en,
    output logic irq_q
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            irq_q   <= global_sts & global_en;
            past_ok <= 1'b1;
        end
    end

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (irq_q == $past(global_sts && global_en)));

endmodule

// File: rtl/audio_irq_aggr.sv
module audio_irq_aggr
    import aud_irq_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CODEC   = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CODEC-1:0]   codec_present,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 resp_irq_flag,
    input  logic                 resp_ovr_flag,
    input  logic [N_STREAMS-1:0] stream_done,
    output logic                 irq
);

    reg_sel_e              sel;
    ring_flags_t           ring;
    logic [WORD_W-1:0]     ctl_q;
    logic [N_CODEC-1:0]    wake_q;
    logic [N_CODEC-1:0]    schg_q;
    logic [WORD_W-1:0]     stat_word;

    always_comb begin
        sel           = reg_sel_e'(reg_sel);
        ring.irq_flag = resp_irq_flag;
        ring.ovr_flag = resp_ovr_flag;
    end

    aud_irq_regs #(.N_STREAMS(N_STREAMS), .N_CODEC(N_CODEC)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .codec_present (codec_present),
        .we            (reg_we),
        .sel           (sel),
        .wdata         (reg_wdata),
        .ctl_q         (ctl_q),
        .wake_q        (wake_q),
        .schg_q        (schg_q)
    );

    aud_irq_status #(.N_STREAMS(N_STREAMS), .N_CODEC(N_CODEC)) u_status (
        .clk  (clk),
        .rst  (rst),
        .ring (ring),
        .schg (schg_q),
        .wake (wake_q),
        .done (stream_done),
        .ctl  (ctl_q),
        .word (stat_word)
    );

    aud_irq_out u_out (
        .clk        (clk),
        .rst        (rst),
        .global_sts (stat_word[GLOBAL_BIT]),
        .global_en  (ctl_q[GLOBAL_BIT]),
        .irq_q      (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_CTL:  reg_rdata = ctl_q;
            SEL_WAKE: reg_rdata = zext_codec(16'(wake_q), N_CODEC);
            SEL_SCHG: reg_rdata = zext_codec(16'(schg_q), N_CODEC);
            default:  reg_rdata = stat_word;
        endcase
    end

endmodule

// File: tb/test_audio_irq_aggr.sv
module test_audio_irq_aggr;

    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] codec_present;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        resp_irq_flag;
    logic        resp_ovr_flag;
    logic [7:0]  stream_done;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    audio_irq_aggr i_audio_irq_aggr (
        .clk           (clk),
        .rst           (rst),
        .codec_present (codec_present),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .resp_irq_flag (resp_irq_flag),
        .resp_ovr_flag (resp_ovr_flag),
        .stream_done   (stream_done),
        .irq           (irq)
    );

    typedef struct packed {
        logic [31:0] ctl;
        logic [13:0] wake;
        logic        ri;
        logic        ro;
        logic [7:0]  done;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h00000000, 14'h0000, 1'b0, 1'b0, 8'h00},
        '{32'h00000000, 14'h0000, 1'b0, 1'b0, 8'h81},
        '{32'h80000001, 14'h0000, 1'b0, 1'b0, 8'h01},
        '{32'h80000002, 14'h0000, 1'b0, 1'b0, 8'h01},
        '{32'h00000001, 14'h0000, 1'b0, 1'b0, 8'h01},
        '{32'hC0000000, 14'h0000, 1'b1, 1'b0, 8'h00},
        '{32'hC0000000, 14'h0000, 1'b0, 1'b1, 8'h00},
        '{32'hC0000000, 14'h0004, 1'b0, 1'b0, 8'h00},
        '{32'hC0000000, 14'h0008, 1'b0, 1'b0, 8'h00},
        '{32'h400000FF, 14'h0000, 1'b0, 1'b0, 8'hFF}
    };

    function automatic logic [31:0] model_word(input logic [31:0] ctl, input logic [13:0] wake,
                                               input logic [13:0] schg, input logic ri,
                                               input logic ro, input logic [7:0] done);
        logic [31:0] w;
        w = 32'h0;
        w[7:0] = done;
        w[30]  = ri | ro | ((schg & wake) != 14'h0);
        w[31]  = ((w & ctl) != 32'h0);
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] ew;
        logic [13:0] schg_m;
        rst = 1'b1; codec_present = 14'h0025; reg_we = 1'b0; reg_sel = 2'd0;
        reg_wdata = '0; resp_irq_flag = 1'b0; resp_ovr_flag = 1'b0; stream_done = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 ctl", v, 32'h0);
        rd(2'd1, v); check("R1 wake", v, 32'h0);
        rd(2'd2, v); check("R1 schg", v, 32'h00000025);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // Vector walk: R5 R6 R7 R8
        schg_m = 14'h0025;
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VECS[i].ctl);
            wr(2'd1, {18'b0, VECS[i].wake});
            resp_irq_flag = VECS[i].ri;
            resp_ovr_flag = VECS[i].ro;
            stream_done   = VECS[i].done;
            @(negedge clk);
            ew = model_word(VECS[i].ctl, VECS[i].wake, schg_m, VECS[i].ri, VECS[i].ro, VECS[i].done);
            rd(2'd3, v); check("R5/R6/R7 status word", v, ew);
            check("R8 irq", {31'b0, irq}, {31'b0, ew[31] & VECS[i].ctl[31]});
        end
        resp_irq_flag = 1'b0; resp_ovr_flag = 1'b0; stream_done = '0;

        // R2 control mask
        wr(2'd0, 32'hFFFFFFFF);
        rd(2'd0, v); check("R2 ctl mask", v, 32'hC00000FF);
        // R3 wake width
        wr(2'd1, 32'hFFFFFFFF);
        rd(2'd1, v); check("R3 wake mask", v, 32'h00003FFF);

        // R8 latency: no change before the edge, follows after it
        wr(2'd1, 32'h0);
        @(negedge clk);
        check("R8 idle irq", {31'b0, irq}, 32'h0);
        stream_done = 8'h08;
        #1;
        check("R8 before edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 after edge", {31'b0, irq}, 32'h1);
        stream_done = 8'h00;
        @(negedge clk);
        check("R8 drop", {31'b0, irq}, 32'h0);

        // R4 write-one-to-clear
        wr(2'd2, 32'h00000004);
        rd(2'd2, v); check("R4 clear one", v, 32'h00000021);
        wr(2'd2, 32'h00000000);
        rd(2'd2, v); check("R4 zero keeps", v, 32'h00000021);
        // R6 with cleared bit: wake on bit 2 no longer triggers, bit 5 does
        wr(2'd1, 32'h00000004);
        rd(2'd3, v); check("R6 cleared source", v[30] ? 32'h1 : 32'h0, 32'h0);
        wr(2'd1, 32'h00000020);
        rd(2'd3, v); check("R6 wake match", v[30] ? 32'h1 : 32'h0, 32'h1);

        // R9 status word write ignored
        wr(2'd3, 32'hFFFFFFFF);
        rd(2'd0, v); check("R9 ctl unchanged", v, 32'hC00000FF);
        rd(2'd1, v); check("R9 wake unchanged", v, 32'h00000020);
        rd(2'd2, v); check("R9 schg unchanged", v, 32'h00000021);

        // R1 reset reloads codec bitmap
        codec_present = 14'h2001;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(2'd2, v); check("R1 reload schg", v, 32'h00002001);
        rd(2'd0, v); check("R1 reload ctl", v, 32'h0);
        check("R1 reload irq", {31'b0, irq}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule